// File: doc/BRIEF.md
# Conflict-Filled Instruction Cache

This block sits between the instruction sequencer, the execute stage and a single-ported program memory. That memory answers both instruction fetches and data accesses. The instruction in execute is two stages behind the one being fetched. When it reads or writes program memory, its access collides with the fetch two slots ahead. In that case the controller gives the memory port to the data access and holds the fetch for one hidden cycle. In the following cycle it reads the instruction and stores it in a small fully-associative cache.

Allocation happens only on such collisions. A fetch with no competing data access always reads memory and never allocates. When a later collision finds its fetch address in the cache, the instruction word comes from the cache, the data access takes the port, and no cycle is lost. A tight loop therefore pays the extra cycles on its first pass only. Replacement picks an empty entry first, otherwise the least recently used entry. A disable input makes every collision stall without looking up or allocating. A flush input empties the cache in one cycle.

Top module: `conflict_icache`

## Requirements
- R1: After reset `stall` and `instr_valid` are low and no entry is valid, so the first collision after reset stalls.
- R2: A fetch with `data_req` low reads memory at `fetch_addr` (`mem_addr` = `fetch_addr`) and returns `mem_rdata` on `instr_out` with `instr_valid` high in the same cycle, without stalling and without allocating; a later collision on that address still stalls.
- R3: A collision (`fetch_req` and `data_req` both high) that misses or finds the cache disabled raises `stall` for exactly one cycle. In that cycle `mem_addr` = `data_addr`, `data_rdata` carries the data word and `instr_valid` is low.
- R4: In the cycle after a stall, the memory port reads the held fetch address, `data_req` is ignored, `instr_valid` is high with the memory word, and (with the cache enabled) the word is allocated.
- R5: A collision whose address hits returns the cached word with `instr_valid` high and `stall` low while `mem_addr` = `data_addr`.
- R6: A fetch with no data access reads memory even when its address is cached.
- R7: `ENTRIES` distinct collided addresses are all held at once; each then hits.
- R8: With every entry valid, a new allocation replaces the least recently used entry; a hit or an allocation counts as a use.
- R9: While `cache_dis` is high, every collision stalls, no hit is returned and nothing is allocated; existing contents survive and hit again once it drops.
- R10: A one-cycle `flush` pulse invalidates every entry, so the next collision on a previously cached address stalls.
- R11: A data access with no fetch uses the memory port in the same cycle with no stall and no `instr_valid`.
- R12: A data write drives `mem_we` high with `mem_wdata` at `data_addr`; a later data read of that address returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Sequencer requests an instruction |
| fetch_addr | input | ADDR_W | Instruction address, held by the sequencer while `stall` is high |
| instr_out | output | INSTR_W | Instruction word |
| instr_valid | output | 1 | `instr_out` is valid this cycle |
| stall | output | 1 | Hidden fetch stall for one cycle |
| data_req | input | 1 | Execute stage accesses program memory |
| data_we | input | 1 | Data access is a write |
| data_addr | input | ADDR_W | Data address |
| data_wdata | input | INSTR_W | Data write word |
| data_rdata | output | INSTR_W | Data read word (memory read data) |
| cache_dis | input | 1 | Bypass lookup and allocation |
| flush | input | 1 | Invalidate all entries |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write |
| mem_addr | output | ADDR_W | Memory port address |
| mem_wdata | output | INSTR_W | Memory port write word |
| mem_rdata | input | INSTR_W | Memory port read word, combinational on `mem_addr` |

## Verification
The bench builds the block with `ENTRIES` = 4 and `ADDR_W` = 8, keeping the 48-bit word. Four entries let a short stream fill the cache completely. It can then force a replacement and steer the choice of victim through the order of hits, so the least-recently-used rule is checked against named victims. The narrow address keeps separate code and data regions in a memory model of modest size.

// File: rtl/icc_pkg.sv
// Package: shared types for the conflict-filled instruction cache.
// Assumes: two-state controller, one fill cycle per collision.
package icc_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_FILL = 1'b1
    } icc_state_e;
endpackage

// File: rtl/icc_tag_store.sv
// Module: icc_tag_store
// Holds valid bits, address tags and instruction words for a fully
// associative store, compares all tags in parallel against a lookup
// address and writes one entry per cycle.
// Assumes: no duplicate tags are written (caller allocates on misses only);
// flush has priority over a write in the same cycle.
module icc_tag_store #(
    parameter int ENTRIES = 40,
    parameter int ADDR_W  = 12,
    parameter int INSTR_W = 48,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [ADDR_W-1:0]  lk_addr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [INSTR_W-1:0] wr_data,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [INSTR_W-1:0] hit_data,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [ADDR_W-1:0]  tag_q  [ENTRIES];
    logic [INSTR_W-1:0] word_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    // Per-entry state: valid bit, tag and word for each slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_vec[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_vec[g] <= 1'b1;
            end
        end

        // Payload registers carry no reset.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                tag_q[g]  <= wr_addr;
                word_q[g] <= wr_data;
            end
        end

        assign match[g] = valid_vec[g] && (tag_q[g] == lk_addr);
    end

    // Reduce the match vector to a hit flag, index and word.
    always_comb begin
        hit      = |match;
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx  = IDX_W'(i);
                hit_data = hit_data | word_q[i];
            end
        end
    end
endmodule

// File: rtl/icc_lru.sv
// Module: icc_lru
// Tracks recency with one age per entry (0 = newest). The ages always form
// a permutation of 0..ENTRIES-1. Chooses a victim: the lowest-numbered
// invalid entry, else the entry of oldest age.
// Assumes: ENTRIES >= 2; at most one touch per cycle.
module icc_lru #(
    parameter int ENTRIES = 40,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touch_age;

    // Age of the entry being touched, selected by index.
    always_comb begin
        touch_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (touch_idx == IDX_W'(i)) touch_age = age_q[i];
        end
    end

    // Age update: the touched entry becomes newest, younger ones age by one.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q[g] <= IDX_W'(g);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(g)) begin
                    age_q[g] <= '0;
                end else if (age_q[g] < touch_age) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end
    end

    // Victim choice: a free slot first, otherwise the oldest entry.
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/conflict_icache.sv
// Module: conflict_icache (top)
// Arbitrates a single-ported program memory between instruction fetch and
// an execute-stage data access. On a collision that misses, data goes
// first and the fetch follows one cycle later and is allocated. On a
// collision that hits, the cached word is returned at no cost.
// Assumes: mem_rdata is combinational on mem_addr; the sequencer and the
// execute stage hold their inputs while stall is high.
module conflict_icache
    import icc_pkg::*;
#(
    parameter int ENTRIES = 40,
    parameter int ADDR_W  = 12,
    parameter int INSTR_W = 48,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    input  logic [ADDR_W-1:0]  fetch_addr,
    output logic [INSTR_W-1:0] instr_out,
    output logic               instr_valid,
    output logic               stall,
    input  logic               data_req,
    input  logic               data_we,
    input  logic [ADDR_W-1:0]  data_addr,
    input  logic [INSTR_W-1:0] data_wdata,
    output logic [INSTR_W-1:0] data_rdata,
    input  logic               cache_dis,
    input  logic               flush,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [INSTR_W-1:0] mem_wdata,
    input  logic [INSTR_W-1:0] mem_rdata
);
    icc_state_e         state_q;
    logic [ADDR_W-1:0]  fill_addr_q;
    logic               in_fill;
    logic               collide;
    logic               hit;
    logic               hit_use;
    logic [IDX_W-1:0]   hit_idx;
    logic [INSTR_W-1:0] hit_data;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim_idx;
    logic               alloc;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;

    assign in_fill = (state_q == ST_FILL);
    assign collide = fetch_req && data_req;
    assign hit_use = hit && !cache_dis;
    assign stall   = !in_fill && collide && !hit_use;
    assign alloc   = in_fill && !cache_dis && !flush;

    assign touch_en  = alloc || (!in_fill && collide && hit_use);
    assign touch_idx = in_fill ? victim_idx : hit_idx;

    // Controller state: enter the fill cycle on a stall, return after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            fill_addr_q <= '0;
        end else if (stall) begin
            state_q     <= ST_FILL;
            fill_addr_q <= fetch_addr;
        end else begin
            state_q     <= ST_RUN;
        end
    end

    // Memory port owner: fill read, then data access, then plain fetch.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = data_wdata;
        if (in_fill) begin
            mem_en   = 1'b1;
            mem_addr = fill_addr_q;
        end else if (data_req) begin
            mem_en   = 1'b1;
            mem_we   = data_we;
            mem_addr = data_addr;
        end else if (fetch_req) begin
            mem_en   = 1'b1;
            mem_addr = fetch_addr;
        end
    end

    // Instruction source: memory unless a collision was served by the cache.
    always_comb begin
        instr_valid = in_fill || (fetch_req && (!data_req || hit_use));
        instr_out   = (in_fill || !data_req) ? mem_rdata : hit_data;
    end

    assign data_rdata = mem_rdata;

    icc_tag_store #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .INSTR_W (INSTR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_addr   (fetch_addr),
        .wr_en     (alloc),
        .wr_idx    (victim_idx),
        .wr_addr   (fill_addr_q),
        .wr_data   (mem_rdata),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_data  (hit_data),
        .valid_vec (valid_vec)
    );

    icc_lru #(
        .ENTRIES (ENTRIES)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );
endmodule

// File: rtl/conflict_icache_chk.sv
// Module: conflict_icache_chk
// Temporal checks on the arbitration and stall protocol, bound to the top.
// Assumes: upstream holds fetch_addr across the stall.
module conflict_icache_chk #(
    parameter int ADDR_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              data_req,
    input logic [ADDR_W-1:0] data_addr,
    input logic              cache_dis,
    input logic              instr_valid,
    input logic              stall,
    input logic              in_fill,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr
);
    // R3: a stall lasts one cycle.
    a_r3_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R3: a stall only comes from a collision, and it gives the port to data.
    a_r3_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (fetch_req && data_req && !instr_valid && mem_addr == data_addr));

    // R4: the cycle after a stall delivers the instruction from the held address.
    a_r4_fill_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (instr_valid && mem_en && mem_addr == $past(fetch_addr)));

    // R9: with the cache disabled, every collision outside a fill stalls.
    a_r9_disabled_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_dis && fetch_req && data_req && !in_fill) |-> stall);

    // R5: a collision without a stall is a hit: instruction present, data owns port.
    a_r5_hit_serves: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && data_req && !in_fill && !stall) |-> (instr_valid && mem_addr == data_addr));

    // R11: no fetch, no instruction and no stall outside a fill.
    a_r11_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_req && !in_fill) |-> (!instr_valid && !stall));
endmodule

bind conflict_icache conflict_icache_chk #(
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/conflict_icache_bench.sv
`timescale 1ns/1ps
module conflict_icache_bench;
    localparam int AW = 8;
    localparam int IW = 48;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [IW-1:0] instr_out;
    logic          instr_valid;
    logic          stall;
    logic          data_req = 1'b0;
    logic          data_we = 1'b0;
    logic [AW-1:0] data_addr = '0;
    logic [IW-1:0] data_wdata = '0;
    logic [IW-1:0] data_rdata;
    logic          cache_dis = 1'b0;
    logic          flush = 1'b0;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [IW-1:0] mem_wdata;
    logic [IW-1:0] mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [IW-1:0] pmem [1 << AW];
    logic [IW-1:0] exp_q [$];
    string         req_q [$];

    always #2.5 clk = ~clk;

    conflict_icache #(.ENTRIES(NE), .ADDR_W(AW), .INSTR_W(IW)) u_conflict_icache (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .instr_out(instr_out), .instr_valid(instr_valid), .stall(stall),
        .data_req(data_req), .data_we(data_we), .data_addr(data_addr),
        .data_wdata(data_wdata), .data_rdata(data_rdata), .cache_dis(cache_dis),
        .flush(flush), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: combinational read, write on the clock edge.
    assign mem_rdata = pmem[mem_addr];
    always @(posedge clk) if (mem_en && mem_we) pmem[mem_addr] <= mem_wdata;

    function automatic logic [IW-1:0] pattern(input int a);
        return {16'hC0DE, 16'(a * 37), 8'(~a), 8'(a ^ 8'h5A)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [IW-1:0] act, input logic [IW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: pop the expected word whenever an instruction appears.
    always @(negedge clk) begin
        if (rst_n && instr_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected instr_valid", instr_out, '0);
            end else begin
                logic [IW-1:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(instr_out == e, r, "instr_out", instr_out, e);
            end
        end
    end

    // Driver: one cycle of stimulus with expected stall and port address.
    task automatic step(input logic f, input logic [AW-1:0] fa, input logic d,
                        input logic [AW-1:0] da, input logic exp_stall,
                        input logic [AW-1:0] exp_ma, input string req);
        fetch_req  = f;
        fetch_addr = fa;
        data_req   = d;
        data_addr  = da;
        data_we    = 1'b0;
        if (f && !exp_stall) begin
            exp_q.push_back(pmem[fa]);
            req_q.push_back(req);
        end
        @(negedge clk);
        chk(stall == exp_stall, req, "stall", IW'(stall), IW'(exp_stall));
        if (f || d) chk(mem_addr == exp_ma, req, "mem_addr", IW'(mem_addr), IW'(exp_ma));
        if (d && exp_ma == da) chk(data_rdata == pmem[da], req, "data_rdata", data_rdata, pmem[da]);
        @(posedge clk);
        #1;
    endtask

    task automatic miss(input logic [AW-1:0] fa, input logic [AW-1:0] da, input string req);
        step(1'b1, fa, 1'b1, da, 1'b1, da, req);
        step(1'b1, fa, 1'b1, da, 1'b0, fa, req);
    endtask

    task automatic hit(input logic [AW-1:0] fa, input logic [AW-1:0] da, input string req);
        step(1'b1, fa, 1'b1, da, 1'b0, da, req);
    endtask

    task automatic idle();
        fetch_req = 1'b0; data_req = 1'b0; data_we = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) pmem[i] = pattern(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        chk(stall == 1'b0, "R1", "stall after reset", IW'(stall), '0);
        chk(instr_valid == 1'b0, "R1", "instr_valid after reset", IW'(instr_valid), '0);
        @(posedge clk); #1;

        // R11: data access alone
        step(1'b0, 8'h00, 1'b1, 8'hC0, 1'b0, 8'hC0, "R11");
        // R2: plain fetch reads memory, does not allocate
        step(1'b1, 8'h10, 1'b0, 8'h00, 1'b0, 8'h10, "R2");
        // R1 / R2 / R3 / R4: first collision misses and fills
        miss(8'h10, 8'hC1, "R2");
        // R5: collision now hits
        hit(8'h10, 8'hC2, "R5");
        // R6: non-colliding fetch of a cached address still reads memory
        step(1'b1, 8'h10, 1'b0, 8'h00, 1'b0, 8'h10, "R6");

        // R7: fill the remaining entries, then all hit
        miss(8'h11, 8'hC3, "R7");
        miss(8'h12, 8'hC4, "R4");
        miss(8'h13, 8'hC5, "R7");
        hit(8'h10, 8'hC6, "R7");
        hit(8'h11, 8'hC7, "R7");
        hit(8'h12, 8'hC8, "R7");
        hit(8'h13, 8'hC9, "R7");

        // R8: touch 10 again, so 11 is oldest and is replaced by 14
        hit(8'h10, 8'hCA, "R8");
        miss(8'h14, 8'hCB, "R8");
        hit(8'h10, 8'hCC, "R8");
        hit(8'h12, 8'hCD, "R8");
        hit(8'h13, 8'hCE, "R8");
        hit(8'h14, 8'hCF, "R8");
        miss(8'h11, 8'hD0, "R8");
        // 10 was oldest among 10,12,13,14 and is gone; 12 survives
        miss(8'h10, 8'hD1, "R8");
        hit(8'h14, 8'hD2, "R8");

        // R9: disabled cache stalls even on a cached address, no allocation
        cache_dis = 1'b1;
        miss(8'h14, 8'hD3, "R9");
        miss(8'h20, 8'hD4, "R9");
        cache_dis = 1'b0;
        miss(8'h20, 8'hD5, "R9");
        hit(8'h14, 8'hD6, "R9");

        // R10: one-cycle flush empties the cache
        flush = 1'b1;
        idle();
        flush = 1'b0;
        miss(8'h14, 8'hD7, "R10");

        // R12: data write reaches memory, then reads back
        fetch_req  = 1'b0;
        data_req   = 1'b1;
        data_we    = 1'b1;
        data_addr  = 8'hE0;
        data_wdata = 48'h1234_5678_9ABC;
        @(negedge clk);
        chk(mem_we == 1'b1, "R12", "mem_we", IW'(mem_we), IW'(1));
        chk(mem_addr == 8'hE0, "R12", "mem_addr", IW'(mem_addr), IW'(8'hE0));
        chk(mem_wdata == 48'h1234_5678_9ABC, "R12", "mem_wdata", mem_wdata, 48'h1234_5678_9ABC);
        @(posedge clk); #1;
        data_we = 1'b0;
        @(negedge clk);
        chk(data_rdata == 48'h1234_5678_9ABC, "R12", "readback", data_rdata, 48'h1234_5678_9ABC);
        @(posedge clk); #1;
        idle();
        idle();

        chk(exp_q.size() == 0, "R4", "instructions missing", IW'(exp_q.size()), '0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule